// File: doc/BRIEF.md
# Programmable Single-Pulse Delay Timer

The block takes a one-clock-wide pulse and reproduces it a programmable number of clock cycles later. It holds no copy of the incoming bit stream. A pulse that arrives while the block is idle arms a loadable down-counter with the requested delay. The counter then decrements once per clock. When it runs out, the block emits a one-clock output pulse and clears the counter back to its idle value. Only one pulse can be in flight at a time.

The delay is read from `delay_i` in the cycle the block arms, so later changes to that input do not move a countdown already running. While a countdown is running, `busy_o` is high and further input pulses are discarded. Delays of 0 and 1 both produce a registered pass-through with a latency of one cycle. Delays larger than `MAX_DELAY` (default 3454) are limited to `MAX_DELAY`.

Top module: `pulse_delay_timer`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises with no pulse applied, `pulse_o` and `busy_o` are 0.
- R2: If `pulse_i` is high in cycle c while the block is idle and the effective delay N is 2 or more, `pulse_o` is high in cycle c+N and only in that cycle.
- R3: If the effective delay is 0 or 1 when the block arms, `pulse_o` is high in cycle c+1 and `busy_o` stays 0.
- R4: After arming with N of 2 or more in cycle c, `busy_o` is 1 in cycles c+1 through c+N-1 and 0 in cycle c+N, the cycle in which `pulse_o` is high.
- R5: An input pulse that arrives while `busy_o` is 1 is ignored. It creates no extra output and does not shift the pending output.
- R6: `delay_i` is sampled only in the arming cycle. Changing it during a countdown has no effect on when the output pulse appears.
- R7: An effective delay is `min(delay_i, MAX_DELAY)`. For example, `delay_i` = 4095 with the default parameters gives an output 3454 cycles after the input.
- R8: An input pulse in the same cycle as an output pulse, when `busy_o` is 0, is accepted and starts a new countdown.
- R9: While the block is idle and `pulse_i` stays low, `pulse_o` stays 0 whatever `delay_i` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | One-cycle input pulse |
| delay_i | input | DLY_W | Requested delay in cycles |
| pulse_o | output | 1 | Delayed one-cycle pulse |
| busy_o | output | 1 | Countdown in progress, input pulses ignored |

## Verification
The bench probes the delay endpoints.

- At N = 0, 1 and 2, an off-by-one in the terminal compare would show up as an output one cycle early or late, or as a spurious busy cycle.
- At `MAX_DELAY`, and at a value above it, a missing clamp would make the 4095 case land 641 cycles late.

It also probes inputs that must not matter.

- A pulse injected mid-countdown would restart or double the output if the busy gate failed.
- A `delay_i` change mid-countdown would move the output if the preset were re-read live.

Finally, it drives a pulse in exactly the output cycle. This catches a controller that releases `busy_o` one cycle too late and drops a legal back-to-back pulse.

// File: rtl/pdly_pkg.sv
package pdly_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } pdly_state_e;
endpackage

// File: rtl/pdly_clamp.sv
module pdly_clamp #(
  parameter int unsigned W   = 12,
  parameter int unsigned MAX = 3454
) (
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  localparam logic [W-1:0] MaxW = W'(MAX);

  always_comb begin
    dout_o = (din_i > MaxW) ? MaxW : din_i;
  end
endmodule

// File: rtl/pdly_counter.sv
module pdly_counter #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         dec_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ld_i)  cnt_q <= ld_val_i;
    else if (dec_i) cnt_q <= cnt_q - W'(1);
  end

  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/pdly_ctrl.sv
module pdly_ctrl
  import pdly_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         pulse_i,
  input  logic [W-1:0] dly_i,
  input  logic         last_i,
  output logic         ld_o,
  output logic [W-1:0] ld_val_o,
  output logic         dec_o,
  output logic         pulse_o,
  output logic         busy_o
);
  pdly_state_e state_q, state_d;
  logic        pulse_q, pulse_d;
  logic        arm, short_dly, done;

  assign arm       = pulse_i && (state_q == ST_IDLE);
  assign short_dly = (dly_i <= W'(1));
  assign done      = (state_q == ST_RUN) && last_i;

  always_comb begin
    state_d  = state_q;
    pulse_d  = 1'b0;
    ld_o     = 1'b0;
    ld_val_o = '0;
    dec_o    = 1'b0;
    if (arm) begin
      if (short_dly) begin
        pulse_d = 1'b1;
      end else begin
        state_d  = ST_RUN;
        ld_o     = 1'b1;
        ld_val_o = dly_i - W'(1);
      end
    end else if (done) begin
      // terminal count: emit pulse, preset counter back to idle value
      state_d  = ST_IDLE;
      pulse_d  = 1'b1;
      ld_o     = 1'b1;
      ld_val_o = '0;
    end else if (state_q == ST_RUN) begin
      dec_o = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      state_q <= state_d;
      pulse_q <= pulse_d;
    end
  end

  assign pulse_o = pulse_q;
  assign busy_o  = (state_q == ST_RUN);
endmodule

// File: rtl/pulse_delay_timer.sv
module pulse_delay_timer #(
  parameter int unsigned MAX_DELAY = 3454,
  parameter int unsigned DLY_W     = $clog2(MAX_DELAY + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             pulse_o,
  output logic             busy_o
);
  logic [DLY_W-1:0] dly_eff;
  logic             ld, dec, last;
  logic [DLY_W-1:0] ld_val;

  pdly_clamp #(.W(DLY_W), .MAX(MAX_DELAY)) u_clamp (
    .din_i  (delay_i),
    .dout_o (dly_eff)
  );

  pdly_ctrl #(.W(DLY_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pulse_i  (pulse_i),
    .dly_i    (dly_eff),
    .last_i   (last),
    .ld_o     (ld),
    .ld_val_o (ld_val),
    .dec_o    (dec),
    .pulse_o  (pulse_o),
    .busy_o   (busy_o)
  );

  pdly_counter #(.W(DLY_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_i     (ld),
    .ld_val_i (ld_val),
    .dec_i    (dec),
    .last_o   (last)
  );
endmodule

// File: rtl/pulse_delay_timer_chk.sv
module pulse_delay_timer_chk #(
  parameter int unsigned MAX_DELAY = 3454,
  parameter int unsigned DLY_W     = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pulse_i,
  input logic [DLY_W-1:0] delay_i,
  input logic             pulse_o,
  input logic             busy_o
);
  logic short_req;
  assign short_req = (delay_i <= DLY_W'(1));

  // R1: outputs quiet in reset
  always_comb begin
    if (!rst_ni) a_r1_reset_quiet: assert (!pulse_o && !busy_o);
  end

  // R3: short delay is a one-cycle pass-through without busy
  a_r3_short_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i && !busy_o && short_req |=> pulse_o && !busy_o);

  // R2/R4: longer delay arms busy with no immediate output
  a_r4_arm_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i && !busy_o && !short_req |=> busy_o && !pulse_o);

  // R4: busy and output pulse never coincide
  a_r4_busy_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !pulse_o);

  // R2: a countdown only ends with an output pulse
  a_r2_end_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> busy_o || pulse_o);

  // R9: no output without arming
  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !pulse_i |=> !pulse_o);
endmodule

bind pulse_delay_timer pulse_delay_timer_chk #(
  .MAX_DELAY(MAX_DELAY),
  .DLY_W(DLY_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pulse_i (pulse_i),
  .delay_i (delay_i),
  .pulse_o (pulse_o),
  .busy_o  (busy_o)
);

// File: tb/pulse_delay_timer_test.sv
`timescale 1ns/1ps
module pulse_delay_timer_test;
  localparam int MAX_DELAY = 3454;
  localparam int DLY_W     = 12;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             pulse_i = 1'b0;
  logic [DLY_W-1:0] delay_i = '0;
  logic             pulse_o, busy_o;

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference model state
  bit m_busy = 1'b0;
  bit m_pulse = 1'b0;
  int m_left = 0;

  always #2 clk_i = ~clk_i;

  pulse_delay_timer #(.MAX_DELAY(MAX_DELAY), .DLY_W(DLY_W)) uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (pulse_i),
    .delay_i (delay_i),
    .pulse_o (pulse_o),
    .busy_o  (busy_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 1'b0; m_pulse = 1'b0; m_left = 0;
    end else begin
      m_pulse = 1'b0;
      if (m_busy) begin
        m_left = m_left - 1;
        if (m_left == 0) begin m_pulse = 1'b1; m_busy = 1'b0; end
      end else if (pulse_i) begin
        int d;
        d = (int'(delay_i) > MAX_DELAY) ? MAX_DELAY : int'(delay_i);
        if (d <= 1) m_pulse = 1'b1;
        else begin m_busy = 1'b1; m_left = d - 1; end
      end
    end
  end

  always @(negedge clk_i) begin
    if (!done) begin
      n_cmp++;
      if (pulse_o !== m_pulse || busy_o !== m_busy) begin
        n_bad++;
        $display("FAIL %s t=%0t pulse_o=%b busy_o=%b expected pulse_o=%b busy_o=%b",
                 cur_req, $time, pulse_o, busy_o, m_pulse, m_busy);
      end
    end
  end

  task automatic fire(input int d);
    @(negedge clk_i);
    delay_i = DLY_W'(d);
    pulse_i = 1'b1;
    @(negedge clk_i);
    pulse_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    cur_req = "R1";
    idle(3);
    rst_ni = 1'b1;
    idle(2);

    cur_req = "R2";
    fire(2);  idle(4);
    fire(5);  idle(8);
    fire(37); idle(40);

    cur_req = "R3";
    fire(0); idle(3);
    fire(1); idle(3);

    cur_req = "R4";
    fire(3); idle(5);

    cur_req = "R5";
    fire(50); idle(10);
    pulse_i = 1'b1; delay_i = 12'd2; @(negedge clk_i); pulse_i = 1'b0;
    idle(15);
    pulse_i = 1'b1; @(negedge clk_i); pulse_i = 1'b0;
    idle(30);

    cur_req = "R6";
    fire(30); idle(5);
    delay_i = 12'd3; idle(5);
    delay_i = 12'd200; idle(30);

    cur_req = "R8";
    fire(6);
    while (pulse_o !== 1'b1) @(negedge clk_i);
    pulse_i = 1'b1; delay_i = 12'd4; @(negedge clk_i); pulse_i = 1'b0;
    idle(8);

    cur_req = "R9";
    for (int i = 0; i < 20; i++) begin
      delay_i = DLY_W'(i * 97);
      @(negedge clk_i);
    end

    cur_req = "R7";
    fire(MAX_DELAY); idle(MAX_DELAY + 5);
    fire(4095);      idle(MAX_DELAY + 5);
    fire(MAX_DELAY - 1); idle(MAX_DELAY + 5);

    finish_run();
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired during %s", cur_req);
      finish_run();
    end
  end
endmodule